// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense Logic

This block watches one bank of general-purpose input pins and turns selected pin activity into a single bank interrupt. Each pin is first brought into the local clock domain by a multi-flop synchronizer. The synchronized value is then compared with its value one cycle earlier to find rising and falling transitions, or it is used directly as a level.

Three per-pin configuration registers choose what counts as an event for each pin:
- The level-select register picks level sensing (1) or edge sensing (0).
- The polarity register picks rising edge or active-high (1), or falling edge or active-low (0).
- The any-edge register makes an edge-sensed pin respond to both transitions.

A detected event on an enabled pin sets a sticky status bit. Software clears status bits by writing ones to them. The OR of the enabled status bits drives the interrupt line.

Configuration goes through a simple write port and a combinational read port. Each register is 32 bits wide, and bit i belongs to pin i. The addresses are: 0 enable, 1 polarity, 2 level-select, 3 any-edge, 4 status (write 1 to clear), and 5 the synchronized pin values (read only). Addresses 6 and 7 read as zero and ignore writes.

Top module: `gpio_pin_sense`

## Requirements
- R1: After reset every register reads 0, so all pins are falling-edge sensed, disabled, and have no status pending. The interrupt output is 0.
- R2: Writes to addresses 0 to 3 store the enable, polarity, level-select and any-edge vectors, and reads return them, with bit i belonging to pin i. Address 6 reads 0.
- R3: A pin with level-select 0, any-edge 0 and polarity 1 sets its status on a synchronized 0-to-1 transition only.
- R4: A pin with level-select 0, any-edge 0 and polarity 0 sets its status on a synchronized 1-to-0 transition only.
- R5: A pin with level-select 0 and any-edge 1 sets its status on either transition, whatever its polarity bit.
- R6: A pin with level-select 1 sets its status while its synchronized value equals its polarity bit (1 is active high, 0 is active low). The any-edge bit is ignored.
- R7: A status bit is set only while the pin's enable bit is 1. An event on a disabled pin leaves the status at address 4 unchanged.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Without a clear, a status bit stays set after its condition goes away.
- R9: A level-sensed pin whose level is still active cannot be cleared: its status is set again by the same clock edge.
- R10: When an event and a write-1 clear hit the same status bit at the same edge, the bit ends up set. Other bits in the same write are cleared.
- R11: The interrupt output is 1 exactly when some status bit and its enable bit are both 1. Clearing an enable bit masks that pin without clearing its status.
- R12: With the default two synchronizer stages, a pin change is visible at address 5 after two clock edges. The resulting edge status is set at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Asynchronous pin inputs of the bank |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | NUM_PINS | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | NUM_PINS | Read data, combinational from rdAddr |
| irqOut | output | 1 | Bank interrupt |

## Verification
A register write takes effect at the edge where wrEn is high, and a read reflects it immediately. A pin change made between edges reaches the synchronized readback after two edges and a status bit after three. The interrupt follows status in the same cycle.

The bench drives inputs on falling edges and samples 1 ns after a rising edge. For each edge mode it checks that status is still clear after the second edge and set after the third. The collision case times a falling pin so that its event lands on exactly the edge that carries the clear write.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_ENABLE   = 3'd0,
    SEL_POLARITY = 3'd1,
    SEL_LEVEL    = 3'd2,
    SEL_ANYEDGE  = 3'd3,
    SEL_STATUS   = 3'd4,
    SEL_RAWPINS  = 3'd5
  } regSel_e;

  // One write strobe per writable register
  typedef struct packed {
    logic enableWr;
    logic polarityWr;
    logic levelWr;
    logic anyEdgeWr;
    logic statusClr;
  } ctrlStrobes_t;

endpackage

// File: rtl/pin_sense_sync.sv
module pin_sense_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= g_stage[s-1].q;
      end
    end
  end

  assign syncOut = g_stage[STAGES-1].q;

endmodule

// File: rtl/pin_sense_ctrl.sv
module pin_sense_ctrl
  import pin_sense_pkg::*;
(
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  output ctrlStrobes_t          strobes
);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (wrAddr)
        SEL_ENABLE:   strobes.enableWr   = 1'b1;
        SEL_POLARITY: strobes.polarityWr = 1'b1;
        SEL_LEVEL:    strobes.levelWr    = 1'b1;
        SEL_ANYEDGE:  strobes.anyEdgeWr  = 1'b1;
        SEL_STATUS:   strobes.statusClr  = 1'b1;
        default:      strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/pin_sense_dp.sv
module pin_sense_dp
  import pin_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [NUM_PINS-1:0]   wrData,
  input  logic [NUM_PINS-1:0]   syncIn,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [NUM_PINS-1:0]   rdData,
  output logic                  irqOut
);

  logic [NUM_PINS-1:0] enableReg, polarityReg, levelReg, anyEdgeReg;
  logic [NUM_PINS-1:0] statusReg, prevIn, evtVec, clrMask, setMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg   <= '0;
      polarityReg <= '0;
      levelReg    <= '0;
      anyEdgeReg  <= '0;
    end else begin
      if (strobes.enableWr)   enableReg   <= wrData;
      if (strobes.polarityWr) polarityReg <= wrData;
      if (strobes.levelWr)    levelReg    <= wrData;
      if (strobes.anyEdgeWr)  anyEdgeReg  <= wrData;
    end
  end

  // Per-pin event selection
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic riseP, fallP;
    always_comb begin
      riseP = syncIn[p] & ~prevIn[p];
      fallP = ~syncIn[p] & prevIn[p];
      if (levelReg[p])        evtVec[p] = polarityReg[p] ? syncIn[p] : ~syncIn[p];
      else if (anyEdgeReg[p]) evtVec[p] = riseP | fallP;
      else                    evtVec[p] = polarityReg[p] ? riseP : fallP;
    end
  end

  assign clrMask = strobes.statusClr ? wrData : '0;
  assign setMask = evtVec & enableReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn    <= '0;
      statusReg <= '0;
    end else begin
      prevIn    <= syncIn;
      statusReg <= (statusReg & ~clrMask) | setMask;
    end
  end

  assign irqOut = |(statusReg & enableReg);

  always_comb begin
    case (rdAddr)
      SEL_ENABLE:   rdData = enableReg;
      SEL_POLARITY: rdData = polarityReg;
      SEL_LEVEL:    rdData = levelReg;
      SEL_ANYEDGE:  rdData = anyEdgeReg;
      SEL_STATUS:   rdData = statusReg;
      SEL_RAWPINS:  rdData = syncIn;
      default:      rdData = '0;
    endcase
  end

  // A status bit can only rise while its pin was enabled
  assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & ~$past(statusReg) & ~$past(enableReg)) == '0)
    else $error("status rose on a disabled pin");

  // An enabled event forces the bit set regardless of a clear
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & $past(setMask)) == $past(setMask))
    else $error("enabled event lost");

  // Cleared bits without a competing event go to zero
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & $past(clrMask & ~setMask)) == '0)
    else $error("write-1 clear ignored");

  // Set bits not cleared stay set
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (~statusReg & $past(statusReg & ~clrMask)) == '0)
    else $error("status bit dropped without clear");

  // No enabled pin means no interrupt
  assert_masked_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |-> !irqOut)
    else $error("interrupt with all pins masked");

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import pin_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [NUM_PINS-1:0]   wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [NUM_PINS-1:0]   rdData,
  output logic                  irqOut
);

  logic [NUM_PINS-1:0] syncPins;
  ctrlStrobes_t        strobes;

  pin_sense_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncPins)
  );

  pin_sense_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobes (strobes)
  );

  pin_sense_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .syncIn  (syncPins),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/gpio_pin_sense_bench.sv
`timescale 1ns/1ps
module gpio_pin_sense_bench;

  localparam int N = 32;
  localparam logic [2:0] A_EN = 3'd0, A_POL = 3'd1, A_LVL = 3'd2, A_ANY = 3'd3,
                         A_STAT = 3'd4, A_RAW = 3'd5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  pinIn = '0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [N-1:0]  wrData = '0;
  logic [2:0]    rdAddr = A_STAT;
  logic [N-1:0]  rdData;
  logic          irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pin_sense #(.NUM_PINS(N), .SYNC_STAGES(2)) u_gpio_pin_sense (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic settle(logic [N-1:0] p);
    @(negedge clk); pinIn = p;
    repeat (4) @(posedge clk); #1;
  endtask

  // Edge modes: transition p0 -> p1, status expected at third edge
  task automatic runEdge(string tag, logic pol, logic any,
                         logic [N-1:0] p0, logic [N-1:0] p1, logic [N-1:0] exp);
    logic [N-1:0] v;
    wr(A_EN, '0); wr(A_LVL, '0); wr(A_POL, {N{pol}}); wr(A_ANY, {N{any}});
    settle(p0);
    wr(A_EN, '1); wr(A_STAT, '1);
    @(negedge clk); pinIn = p1;
    repeat (2) @(posedge clk); #1;
    rd(A_STAT, v); chk({tag, " R12 not yet at 2nd edge"}, v, '0);
    @(posedge clk); #1;
    rd(A_STAT, v); chk({tag, " status at 3rd edge"}, v, exp);
    chk({tag, " R11 irq"}, {{(N-1){1'b0}}, irqOut}, {{(N-1){1'b0}}, exp != '0});
  endtask

  // Level modes
  task automatic runLevel(string tag, logic pol, logic [N-1:0] p);
    logic [N-1:0] v, exp;
    exp = pol ? p : ~p;
    wr(A_EN, '0); wr(A_POL, {N{pol}}); wr(A_LVL, '1); wr(A_ANY, '1); // any-edge ignored (R6)
    settle(p);
    wr(A_STAT, '1);
    wr(A_EN, '1);
    @(posedge clk); #1;
    rd(A_STAT, v); chk({tag, " R6 level status"}, v, exp);
    wr(A_STAT, '1);
    rd(A_STAT, v); chk({tag, " R9 clear while active"}, v, exp);
    settle(pol ? '0 : '1);
    rd(A_STAT, v); chk({tag, " R8 sticky after level drop"}, v, exp);
    wr(A_STAT, '0);
    rd(A_STAT, v); chk({tag, " R8 write 0 keeps"}, v, exp);
    wr(A_STAT, '1);
    rd(A_STAT, v); chk({tag, " R8 write 1 clears"}, v, '0);
    chk({tag, " R11 irq low"}, {{(N-1){1'b0}}, irqOut}, '0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] v;
    logic [N-1:0] pa [3];
    logic [N-1:0] pb [3];
    pa[0] = '0;            pb[0] = '1;
    pa[1] = '1;            pb[1] = '0;
    pa[2] = 32'hA5A5_0F0F; pb[2] = 32'h5A5A_0FF0;

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk($sformatf("R1 reset addr %0d", a), v, '0);
    end
    chk("R1 irq after reset", {{(N-1){1'b0}}, irqOut}, '0);

    // R2 register write and readback
    for (int a = 0; a < 4; a++) wr(a[2:0], 32'hC3A5_0000 | (a * 32'h1111) | (1 << a));
    for (int a = 0; a < 4; a++) begin
      rd(a[2:0], v);
      chk($sformatf("R2 readback addr %0d", a), v, 32'hC3A5_0000 | (a * 32'h1111) | (1 << a));
    end
    rd(3'd6, v); chk("R2 unused address", v, '0);
    wr(A_EN, '0); wr(A_STAT, '1);

    // R12 synchronizer readback latency
    @(negedge clk); pinIn = 32'h1234_5678;
    @(posedge clk); #1; rd(A_RAW, v); chk("R12 raw after 1 edge", v, '0);
    @(posedge clk); #1; rd(A_RAW, v); chk("R12 raw after 2 edges", v, 32'h1234_5678);
    settle('0);

    // Edge mode sweeps
    for (int k = 0; k < 3; k++) begin
      runEdge($sformatf("R3 rise p%0d", k), 1'b1, 1'b0, pa[k], pb[k], ~pa[k] & pb[k]);
      runEdge($sformatf("R4 fall p%0d", k), 1'b0, 1'b0, pa[k], pb[k], pa[k] & ~pb[k]);
      runEdge($sformatf("R5 any pol1 p%0d", k), 1'b1, 1'b1, pa[k], pb[k], pa[k] ^ pb[k]);
      runEdge($sformatf("R5 any pol0 p%0d", k), 1'b0, 1'b1, pa[k], pb[k], pa[k] ^ pb[k]);
    end

    // Level modes
    runLevel("R6 high", 1'b1, 32'hF00F_3C3C);
    runLevel("R6 low",  1'b0, 32'h0FF0_9669);

    // R7 / R11 enable gating and masking
    wr(A_EN, '0); wr(A_LVL, '0); wr(A_ANY, '0); wr(A_POL, '1);
    settle('0);
    wr(A_STAT, '1);
    wr(A_EN, 32'h5555_5555);
    settle('1);
    rd(A_STAT, v); chk("R7 only enabled pins set", v, 32'h5555_5555);
    wr(A_EN, '1);
    rd(A_STAT, v); chk("R7 late enable sets nothing", v, 32'h5555_5555);
    chk("R11 irq on", {{(N-1){1'b0}}, irqOut}, 1);
    wr(A_EN, 32'hAAAA_AAAA);
    chk("R11 masked by enable", {{(N-1){1'b0}}, irqOut}, '0);
    rd(A_STAT, v); chk("R11 status kept when masked", v, 32'h5555_5555);

    // R10 event and clear at the same edge
    wr(A_EN, '0); wr(A_ANY, '1);
    settle('0);
    wr(A_EN, '1); wr(A_STAT, '1);
    settle(32'h0000_0003);
    rd(A_STAT, v); chk("R10 setup", v, 32'h0000_0003);
    @(negedge clk); pinIn = 32'h0000_0002;
    repeat (2) @(posedge clk);
    wr(A_STAT, 32'h0000_0003);
    rd(A_STAT, v); chk("R10 event beats clear", v, 32'h0000_0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule